// File: doc/BRIEF.md
# CAN Transmit Error Counter with Bus-Off Recovery

This block keeps the 8-bit transmit error count of a CAN node. It also sequences how the node leaves the bus and comes back to it. Software works on the counter through a write port and a read value. The controller's reset-mode bit gates every write. An error-driven bus-off request arrives from the protocol engine. A software write of the maximum value arms a bus-off that takes effect later. In both cases the block loads the counter with 127. It then raises one-cycle pulses that push the controller back into reset mode, clear the receive counter, and set the related status and interrupt bits.

Once reset mode is released, the block counts recovery time in bus-free occurrences. An occurrence is eleven recessive bit samples in a row, seen by a built-in detector on the bit-sample strobe. Each occurrence lowers the counter by one. The occurrence after the counter reaches zero ends the bus-off condition. If reset mode is set again during recovery, the count is frozen. Software can cut recovery short by writing any value below 255 while the node is bus-off. The node then rejoins after a single bus-free occurrence. Error-warning and error-passive changes caused by a software write are reported only once reset mode is cleared.

States: `ST_ACTIVE` (taking part, or idle in reset mode), `ST_PENDING` (software bus-off armed), `ST_OFF_ENTER` (bus-off entered, waiting for reset mode to be seen set), `ST_OFF_HELD` (bus-off, reset mode set, count frozen), `ST_RECOVER` (bus-off, counting occurrences), `ST_CLEARED_HELD` (bus-off cleared by software, reset mode still set) and `ST_REJOIN` (waiting for one occurrence). The transitions are:
- `ST_ACTIVE`→`ST_OFF_ENTER` on an error request with reset mode clear.
- `ST_ACTIVE`/`ST_CLEARED_HELD`→`ST_PENDING` on a write of 255.
- `ST_PENDING`→`ST_ACTIVE` on a write below 255.
- `ST_PENDING`→`ST_OFF_ENTER` when reset mode clears.
- `ST_OFF_ENTER`→`ST_OFF_HELD` when reset mode is set.
- `ST_OFF_HELD`→`ST_RECOVER` when reset mode clears.
- `ST_OFF_HELD`→`ST_CLEARED_HELD` on a write below 255.
- `ST_RECOVER`→`ST_OFF_HELD` when reset mode is set.
- `ST_RECOVER`→`ST_ACTIVE` on the occurrence seen at a count of zero.
- `ST_CLEARED_HELD`→`ST_REJOIN` when reset mode clears.
- `ST_REJOIN`→`ST_CLEARED_HELD` when reset mode is set.
- `ST_REJOIN`→`ST_ACTIVE` on one occurrence.

Top module: `txerr_busoff_ctrl`

## Requirements
- R1: After reset, `tx_count` is 0, `bus_off` is 0 and every pulse output is 0.
- R2: A CPU write takes effect only while `reset_mode` is 1, and `tx_count` shows the written value on the cycle after the write. A write while `reset_mode` is 0 leaves `tx_count` unchanged.
- R3: An error bus-off request is accepted when the node is not bus-off, has no rejoin wait and `reset_mode` is 0. On the next cycle `tx_count` is 127 and `bus_off` is 1, and `force_reset_mode`, `rx_clear_pulse`, `busoff_irq_pulse` and `status_change_pulse` are each high for exactly that one cycle.
- R4: `bit_level` 1 is recessive and 0 is dominant. The detector reports a bus-free occurrence on the 11th consecutive recessive strobe. A dominant strobe restarts the run at zero, and the run also restarts after each report. Runs are counted only while recovering or waiting to rejoin.
- R5: While bus-off with `reset_mode` 0, each occurrence lowers `tx_count` by one. The occurrence that arrives at a count of 0 clears `bus_off`, pulses `status_change_pulse` and returns the node to the bus. A recovery from 127 therefore takes 128 occurrences.
- R6: Setting `reset_mode` during recovery keeps `bus_off` at 1 and holds `tx_count` while the bus idles. Clearing it again resumes the countdown from the held value.
- R7: While bus-off with `reset_mode` 1, a write of 0 to 254 clears `bus_off` on the next cycle and loads the value. After `reset_mode` clears, `bus_join` stays 0 until one bus-free occurrence has been seen.
- R8: A write of 255 while not bus-off loads 255 and does not raise `bus_off` while `reset_mode` stays 1. The first cycle with `reset_mode` 0 then produces the R3 effects.
- R9: A write of 255 while bus-off is ignored: `tx_count` and `bus_off` are unchanged.
- R10: Software writes raise no warning, passive or status pulse while `reset_mode` is 1. On the first cycle with `reset_mode` 0 after an accepted write below 255, `warn_irq_pulse` fires if (`tx_count` ≥ 96) differs from the last reported warning level. `passive_irq_pulse` fires if (`tx_count` ≥ 128) differs from the last reported passive level. `status_change_pulse` fires if either fires. Bus-off entry sets both levels and recovery completion clears them, without warning or passive pulses.
- R11: `bus_join` is 1 exactly when the node is in `ST_ACTIVE` with `reset_mode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle strobe per sampled bus bit |
| bit_level | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| err_busoff_req | input | 1 | Bus-off request from the error logic |
| reset_mode | input | 1 | Controller reset-mode bit |
| cpu_wr_en | input | 1 | CPU write strobe for the counter |
| cpu_wr_data | input | 8 | CPU write value |
| tx_count | output | 8 | Counter value, also the CPU read value |
| bus_off | output | 1 | Bus-off flag |
| bus_join | output | 1 | Node may take part on the bus |
| rx_clear_pulse | output | 1 | Clears the receive error counter |
| force_reset_mode | output | 1 | Sets the controller reset-mode bit |
| status_change_pulse | output | 1 | Error or bus status changed |
| busoff_irq_pulse | output | 1 | Bus-off interrupt set |
| warn_irq_pulse | output | 1 | Error-warning interrupt set |
| passive_irq_pulse | output | 1 | Error-passive interrupt set |

## Verification
Every value from 0 to 254 is written in a permuted order and then released from reset mode. This catches threshold edges placed at 95/96 or 127/128. It also tells a pulse raised on a level change apart from one raised on every write. A full 128-occurrence recovery, frozen after five occurrences, reveals off-by-one errors in the final step and any count that leaks while frozen. Recessive runs broken by a dominant bit one short of eleven show whether the detector restarts or merely pauses.

// File: rtl/txerr_pkg.sv
package txerr_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE       = 3'd0,
        ST_PENDING      = 3'd1,
        ST_OFF_ENTER    = 3'd2,
        ST_OFF_HELD     = 3'd3,
        ST_RECOVER      = 3'd4,
        ST_CLEARED_HELD = 3'd5,
        ST_REJOIN       = 3'd6
    } txerr_state_e;

    function automatic logic is_off_state(input txerr_state_e s);
        return (s == ST_OFF_ENTER) || (s == ST_OFF_HELD) || (s == ST_RECOVER);
    endfunction

    function automatic logic is_waiting_state(input txerr_state_e s);
        return (s == ST_RECOVER) || (s == ST_REJOIN);
    endfunction

endpackage

// File: rtl/txerr_bus_free_det.sv
module txerr_bus_free_det #(
    parameter int FREE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_strobe,
    input  logic bit_level,
    output logic free_occ
);
    localparam int RUN_W = $clog2(FREE_BITS + 1);
    localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(FREE_BITS - 1);

    logic [RUN_W-1:0] run_q;

    // Counts consecutive recessive samples, reports the FREE_BITS-th one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            free_occ <= 1'b0;
        end else begin
            free_occ <= 1'b0;
            if (clr) begin
                run_q <= '0;
            end else if (bit_strobe) begin
                if (!bit_level) begin
                    run_q <= '0;
                end else if (run_q == LAST_RUN) begin
                    run_q    <= '0;
                    free_occ <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assert_dominant_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !bit_level && !clr) |=> (run_q == '0 && !free_occ));

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LAST_RUN);

    assert_occ_needs_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        free_occ |-> $past(bit_strobe && bit_level && !clr));

endmodule

// File: rtl/txerr_level_mon.sv
module txerr_level_mon #(
    parameter int CNT_W         = 8,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval_en,
    input  logic             set_levels,
    input  logic             clr_levels,
    input  logic [CNT_W-1:0] cnt,
    output logic             warn_pulse,
    output logic             passive_pulse,
    output logic             change_pulse
);
    localparam logic [CNT_W-1:0] WARN_V    = CNT_W'(WARN_LIMIT);
    localparam logic [CNT_W-1:0] PASSIVE_V = CNT_W'(PASSIVE_LIMIT);

    logic warn_lvl_q;
    logic passive_lvl_q;
    logic warn_now;
    logic passive_now;

    always_comb begin
        warn_now    = (cnt >= WARN_V);
        passive_now = (cnt >= PASSIVE_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_lvl_q    <= 1'b0;
            passive_lvl_q <= 1'b0;
            warn_pulse    <= 1'b0;
            passive_pulse <= 1'b0;
            change_pulse  <= 1'b0;
        end else begin
            warn_pulse    <= 1'b0;
            passive_pulse <= 1'b0;
            change_pulse  <= 1'b0;
            if (set_levels) begin
                warn_lvl_q    <= 1'b1;
                passive_lvl_q <= 1'b1;
            end else if (clr_levels) begin
                warn_lvl_q    <= 1'b0;
                passive_lvl_q <= 1'b0;
            end else if (eval_en) begin
                warn_lvl_q    <= warn_now;
                passive_lvl_q <= passive_now;
                warn_pulse    <= (warn_now != warn_lvl_q);
                passive_pulse <= (passive_now != passive_lvl_q);
                change_pulse  <= (warn_now != warn_lvl_q) || (passive_now != passive_lvl_q);
            end
        end
    end

    assert_level_follows_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && !set_levels && !clr_levels) |=> (warn_lvl_q == $past(warn_now)));

    assert_pulse_only_on_eval_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_pulse || passive_pulse) |-> $past(eval_en));

endmodule

// File: rtl/txerr_busoff_ctrl.sv
module txerr_busoff_ctrl
    import txerr_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int FREE_BITS     = 11,
    parameter int BUSOFF_LOAD   = 127,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             bit_level,
    input  logic             err_busoff_req,
    input  logic             reset_mode,
    input  logic             cpu_wr_en,
    input  logic [CNT_W-1:0] cpu_wr_data,
    output logic [CNT_W-1:0] tx_count,
    output logic             bus_off,
    output logic             bus_join,
    output logic             rx_clear_pulse,
    output logic             force_reset_mode,
    output logic             status_change_pulse,
    output logic             busoff_irq_pulse,
    output logic             warn_irq_pulse,
    output logic             passive_irq_pulse
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(BUSOFF_LOAD);
    localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};

    txerr_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             eval_due_q, eval_due_d;
    logic             free_occ;
    logic             det_clr;
    logic             wr_ok;
    logic             wr_max;
    logic             enter_off;
    logic             recover_done;
    logic             recover_step;
    logic             eval_en;
    logic             entry_status_q;
    logic             lvl_change;

    assign wr_ok  = cpu_wr_en && reset_mode;
    assign wr_max = (cpu_wr_data == MAX_V);

    // Bus-free detector runs only while an occurrence is awaited.
    assign det_clr = !is_waiting_state(state_q);

    txerr_bus_free_det #(
        .FREE_BITS (FREE_BITS)
    ) i_free_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (det_clr),
        .bit_strobe (bit_strobe),
        .bit_level  (bit_level),
        .free_occ   (free_occ)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!reset_mode && err_busoff_req) state_d = ST_OFF_ENTER;
                else if (wr_ok && wr_max)         state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (!reset_mode)           state_d = ST_OFF_ENTER;
                else if (wr_ok && !wr_max) state_d = ST_ACTIVE;
            end
            ST_OFF_ENTER: begin
                if (reset_mode) state_d = ST_OFF_HELD;
            end
            ST_OFF_HELD: begin
                if (wr_ok && !wr_max) state_d = ST_CLEARED_HELD;
                else if (!reset_mode) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (reset_mode)                     state_d = ST_OFF_HELD;
                else if (free_occ && cnt_q == '0)   state_d = ST_ACTIVE;
            end
            ST_CLEARED_HELD: begin
                if (!reset_mode)          state_d = ST_REJOIN;
                else if (wr_ok && wr_max) state_d = ST_PENDING;
            end
            ST_REJOIN: begin
                if (reset_mode)    state_d = ST_CLEARED_HELD;
                else if (free_occ) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign enter_off    = (state_d == ST_OFF_ENTER) && (state_q != ST_OFF_ENTER);
    assign recover_done = (state_q == ST_RECOVER) && (state_d == ST_ACTIVE);
    assign recover_step = (state_q == ST_RECOVER) && !reset_mode && free_occ && (cnt_q != '0);
    assign eval_en      = eval_due_q && !reset_mode &&
                          ((state_q == ST_ACTIVE) || (state_q == ST_CLEARED_HELD) ||
                           (state_q == ST_REJOIN));

    // Counter and deferred-evaluation flag.
    always_comb begin
        cnt_d      = cnt_q;
        eval_due_d = eval_due_q;
        if (enter_off) begin
            cnt_d      = LOAD_V;
            eval_due_d = 1'b0;
        end else if (recover_step) begin
            cnt_d = cnt_q - 1'b1;
        end else if (wr_ok) begin
            unique case (state_q)
                ST_ACTIVE, ST_PENDING, ST_CLEARED_HELD: begin
                    cnt_d = cpu_wr_data;
                    if (!wr_max) eval_due_d = 1'b1;
                end
                ST_OFF_HELD: begin
                    if (!wr_max) begin
                        cnt_d      = cpu_wr_data;
                        eval_due_d = 1'b1;
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end else if (eval_en) begin
            eval_due_d = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_ACTIVE;
            cnt_q      <= '0;
            eval_due_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            eval_due_q <= eval_due_d;
        end
    end

    // Registered transition pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_reset_mode <= 1'b0;
            rx_clear_pulse   <= 1'b0;
            busoff_irq_pulse <= 1'b0;
            entry_status_q   <= 1'b0;
        end else begin
            force_reset_mode <= enter_off;
            rx_clear_pulse   <= enter_off;
            busoff_irq_pulse <= enter_off;
            entry_status_q   <= enter_off || recover_done;
        end
    end

    txerr_level_mon #(
        .CNT_W         (CNT_W),
        .WARN_LIMIT    (WARN_LIMIT),
        .PASSIVE_LIMIT (PASSIVE_LIMIT)
    ) i_level_mon (
        .clk           (clk),
        .rst_n         (rst_n),
        .eval_en       (eval_en),
        .set_levels    (enter_off),
        .clr_levels    (recover_done),
        .cnt           (cnt_q),
        .warn_pulse    (warn_irq_pulse),
        .passive_pulse (passive_irq_pulse),
        .change_pulse  (lvl_change)
    );

    assign tx_count            = cnt_q;
    assign bus_off             = is_off_state(state_q);
    assign bus_join            = (state_q == ST_ACTIVE) && !reset_mode;
    assign status_change_pulse = entry_status_q || lvl_change;

    assert_opmode_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !reset_mode && !err_busoff_req) |=> $stable(tx_count));

    assert_entry_effects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off) |-> (tx_count == LOAD_V && force_reset_mode && rx_clear_pulse && busoff_irq_pulse));

    assert_recover_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !reset_mode && free_occ && cnt_q != '0) |=> (tx_count == $past(cnt_q) - 1'b1));

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_HELD && !cpu_wr_en) |=> $stable(tx_count));

    assert_pending_no_busoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING && reset_mode) |=> !bus_off);

    assert_max_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_HELD && cpu_wr_en && cpu_wr_data == MAX_V) |=> (bus_off && $stable(tx_count)));

endmodule

// File: tb/test_txerr_busoff_ctrl.sv
module test_txerr_busoff_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       bit_level = 1'b1;
    logic       err_busoff_req = 1'b0;
    logic       reset_mode = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = 8'd0;
    logic [7:0] tx_count;
    logic       bus_off, bus_join, rx_clear_pulse, force_reset_mode;
    logic       status_change_pulse, busoff_irq_pulse, warn_irq_pulse, passive_irq_pulse;

    int checks = 0;
    int fails  = 0;
    logic wl = 1'b0;
    logic pl = 1'b0;

    always #4 clk = ~clk;

    txerr_busoff_ctrl i_txerr_busoff_ctrl (
        .clk                 (clk),
        .rst_n               (rst_n),
        .bit_strobe          (bit_strobe),
        .bit_level           (bit_level),
        .err_busoff_req      (err_busoff_req),
        .reset_mode          (reset_mode),
        .cpu_wr_en           (cpu_wr_en),
        .cpu_wr_data         (cpu_wr_data),
        .tx_count            (tx_count),
        .bus_off             (bus_off),
        .bus_join            (bus_join),
        .rx_clear_pulse      (rx_clear_pulse),
        .force_reset_mode    (force_reset_mode),
        .status_change_pulse (status_change_pulse),
        .busoff_irq_pulse    (busoff_irq_pulse),
        .warn_irq_pulse      (warn_irq_pulse),
        .passive_irq_pulse   (passive_irq_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse vector order: {force, rxclr, boirq, status, warn, passive}
    function automatic int pulses();
        return {force_reset_mode, rx_clear_pulse, busoff_irq_pulse,
                status_change_pulse, warn_irq_pulse, passive_irq_pulse};
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic lvl);
        bit_strobe = 1'b1;
        bit_level  = lvl;
        cyc();
        bit_strobe = 1'b0;
        bit_level  = 1'b1;
    endtask

    task automatic one_free();
        for (int b = 0; b < 11; b++) send_bit(1'b1);
        cyc();
    endtask

    task automatic cpu_write(input logic [7:0] v);
        cpu_wr_en   = 1'b1;
        cpu_wr_data = v;
        cyc();
        cpu_wr_en   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 count", tx_count, 0);
        check("R1 bus_off", bus_off, 0);
        check("R1 pulses", pulses(), 0);
        check("R11 join after reset", bus_join, 1);

        // R2 write ignored outside reset mode
        cpu_write(8'd200);
        check("R2 ignored write", tx_count, 0);

        // R2/R10 sweep of all values below 255, permuted order
        reset_mode = 1'b1;
        cyc();
        for (int i = 0; i < 255; i++) begin
            int v;
            logic ew, ep;
            v = (i * 37) % 255;
            cpu_write(8'(v));
            check("R2 readback", tx_count, v);
            check("R10 no pulse in reset mode", pulses(), 0);
            reset_mode = 1'b0;
            cyc();
            ew = ((v >= 96) != wl);
            ep = ((v >= 128) != pl);
            check("R10 deferred pulses", pulses(), {3'b000, ew | ep, ew, ep});
            check("R11 join in operation", bus_join, 1);
            wl = (v >= 96);
            pl = (v >= 128);
            reset_mode = 1'b1;
            cyc();
        end
        reset_mode = 1'b0;
        cyc();

        // R3 error-driven bus-off
        err_busoff_req = 1'b1;
        cyc();
        err_busoff_req = 1'b0;
        check("R3 load", tx_count, 127);
        check("R3 bus_off", bus_off, 1);
        check("R3 entry pulses", pulses(), 6'b111100);
        check("R11 no join bus-off", bus_join, 0);
        reset_mode = 1'b1;
        cyc();
        check("R3 single-cycle pulses", pulses(), 0);
        reset_mode = 1'b0;
        cyc();

        // R5 recovery, R6 freeze after five occurrences
        for (int k = 1; k <= 5; k++) begin
            one_free();
            check("R5 countdown", tx_count, 127 - k);
        end
        reset_mode = 1'b1;
        cyc();
        for (int b = 0; b < 22; b++) send_bit(1'b1);
        cyc();
        check("R6 frozen count", tx_count, 122);
        check("R6 bus_off kept", bus_off, 1);
        cpu_write(8'd255);
        check("R9 count unchanged", tx_count, 122);
        check("R9 bus_off unchanged", bus_off, 1);
        reset_mode = 1'b0;
        cyc();
        for (int k = 6; k <= 127; k++) begin
            one_free();
            check("R5 countdown", tx_count, 127 - k);
            check("R5 still bus-off", bus_off, 1);
        end
        one_free();
        check("R5 done count", tx_count, 0);
        check("R5 done bus_off", bus_off, 0);
        check("R5 done status pulse", pulses(), 6'b000100);
        check("R11 join after recovery", bus_join, 1);
        wl = 1'b0;
        pl = 1'b0;

        // R8 software-forced bus-off
        reset_mode = 1'b1;
        cyc();
        cpu_write(8'd255);
        check("R8 load 255", tx_count, 255);
        check("R8 deferred", bus_off, 0);
        check("R8 no pulses yet", pulses(), 0);
        cyc();
        check("R8 still deferred", bus_off, 0);
        reset_mode = 1'b0;
        cyc();
        check("R8 load", tx_count, 127);
        check("R8 bus_off", bus_off, 1);
        check("R8 entry pulses", pulses(), 6'b111100);
        reset_mode = 1'b1;
        cyc();

        // R7 software clear during bus-off, R4 detector restart
        cpu_write(8'd40);
        check("R7 bus_off cleared", bus_off, 0);
        check("R7 value loaded", tx_count, 40);
        check("R10 held no pulses", pulses(), 0);
        reset_mode = 1'b0;
        cyc();
        check("R10 level drop pulses", pulses(), 6'b000111);
        check("R7 no join yet", bus_join, 0);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        send_bit(1'b0);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        cyc();
        check("R4 broken run no join", bus_join, 0);
        send_bit(1'b1);
        cyc();
        check("R4 R7 join after one occurrence", bus_join, 1);
        check("R7 count kept", tx_count, 40);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule